// File: doc/BRIEF.md
# Least-Used Interrupt Link Allocator

This block hands out shared interrupt link pins to devices as they are attached, and binds each link to a legacy IRQ line the first time that link is handed out. It keeps an 8-bit use count for every link and for every IRQ line, plus a separate reserved flag per IRQ. An allocation request runs a two-stage minimum search. The first stage picks the least-used link. The second stage runs only if that link has never been routed, and picks the least-used IRQ among those not reserved. The block returns the chosen pin number and, when a new binding is made, emits a one-cycle write of the routing register for the router.

Before the first allocation, system setup may reserve IRQ lines or pre-charge their use counts with single-cycle commands. The first accepted allocation request closes this setup window for good. Commands that break the rules, or that arrive after the window has closed, are dropped and raise a sticky error flag.

Each search stage examines one candidate per clock cycle. A routed allocation takes about 28 cycles from request to done, while an allocation that reuses an existing binding takes about 11.

Top module: `irq_link_alloc`

## Requirements
- R1: On a request, the link with the smallest use count is chosen, with ties going to the lowest index. The chosen link's count is incremented, and at done `pin_o` equals the link index plus one (1 to 8).
- R2: The IRQ stage runs only when the chosen link's routing value is still 0x80 (unrouted). A link that is already routed keeps its binding, and no routing write is issued.
- R3: The IRQ stage skips reserved IRQs and picks the smallest use count, with ties going to the lowest number. It increments that count and issues one `route_wr_o` pulse with `route_link_o` set to the link index and `route_data_o` set to the IRQ number in bits 3:0 and bit 7 (disable) clear.
- R4: After reset, IRQs 0, 1, 2, 8 and 13 are reserved, all IRQ and link counts are zero, every link routes to 0x80, and `busy_o`, `done_o`, `route_wr_o` and `cfg_err_o` are low.
- R5: A reserve command (`cfg_reserve_i`) is legal only when the target IRQ's count is zero or the IRQ is already reserved. A legal reserve removes the IRQ from later IRQ stages.
- R6: A use command (`cfg_use_i`) increments a non-reserved IRQ's count. A use command on a reserved IRQ is illegal.
- R7: Commands are legal only before the first accepted request. A command in the same cycle as that request, or in any later cycle, is dropped.
- R8: An illegal or late command has no effect on the counts or flags, and sets `cfg_err_o`, which stays high until reset. Driving both command inputs at once is illegal.
- R9: Use counts saturate at 255 and never wrap.
- R10: `busy_o` rises in the cycle after an accepted request and stays high until the cycle after the single-cycle `done_o` pulse. A request made while busy is ignored.
- R11: If every IRQ is reserved, the link stays unrouted, no routing write is issued, and `done_o` still pulses with the chosen pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req_i | input | 1 | Allocation request pulse |
| cfg_reserve_i | input | 1 | Reserve the IRQ given on cfg_irq_i |
| cfg_use_i | input | 1 | Count one use of the IRQ given on cfg_irq_i |
| cfg_irq_i | input | 4 | IRQ number for a setup command |
| busy_o | output | 1 | Allocation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pin_o | output | 4 | Chosen pin, 1 to 8, valid with done_o |
| route_wr_o | output | 1 | Routing register write strobe |
| route_link_o | output | 3 | Zero-based link index of the write |
| route_data_o | output | 8 | Routing value: bit 7 disable, bits 3:0 IRQ |
| cfg_err_o | output | 1 | Sticky illegal-command flag |

## Verification
The assertions assume that `alloc_req_i` and the command inputs are synchronous to the clock and are held low while reset is asserted. They also assume that reserved flags change only during the setup window, so that a routing write can be checked against the current reserved set. The directed tests drive every input on the falling edge, issue commands only as single-cycle pulses, and start each scenario from a fresh reset. This keeps the stimulus inside these assumptions, while deliberately placing late and illegal commands to exercise the error path.

// File: rtl/irq_alloc_pkg.sv
package irq_alloc_pkg;
  localparam int CNT_W   = 8;
  localparam int ROUTE_W = 8;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [ROUTE_W-1:0] route_t;

  // Routing value meaning "disabled and never bound"
  localparam route_t ROUTE_OFF = 8'h80;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LSCAN,
    SQ_LPICK,
    SQ_ISCAN,
    SQ_IPICK,
    SQ_DONE
  } seq_state_t;

  // Saturating increment of a use count
  function automatic cnt_t cnt_bump(cnt_t c);
    return (c == '1) ? c : c + cnt_t'(1);
  endfunction

  // A candidate replaces the best so far only when strictly smaller,
  // so an ascending scan keeps the lowest index on ties
  function automatic logic cnt_beats(logic have, cnt_t cand, cnt_t best);
    return !have || (cand < best);
  endfunction
endpackage

// File: rtl/alloc_irq_table.sv
module alloc_irq_table
  import irq_alloc_pkg::*;
#(
  parameter int NUM_IRQS = 16,
  parameter logic [NUM_IRQS-1:0] PERMIT_MASK = 16'hDEF8,
  parameter int IRQ_W = $clog2(NUM_IRQS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     phase_open_i,
  input  logic                     reserve_i,
  input  logic                     use_i,
  input  logic [IRQ_W-1:0]         irq_i,
  input  logic                     inc_i,
  input  logic [IRQ_W-1:0]         inc_idx_i,
  output cnt_t [NUM_IRQS-1:0]      counts_o,
  output logic [NUM_IRQS-1:0]      reserved_o,
  output logic                     accept_o,
  output logic                     reject_o,
  output logic                     err_o
);
  logic cmd_any, legal;
  cnt_t tgt_cnt;
  logic tgt_res;
  logic [NUM_IRQS-1:0] bump;

  assign cmd_any = reserve_i | use_i;
  assign tgt_cnt = counts_o[irq_i];
  assign tgt_res = reserved_o[irq_i];

  always_comb begin
    legal = 1'b0;
    if (phase_open_i && (reserve_i ^ use_i)) begin
      if (reserve_i) legal = (tgt_cnt == '0) || tgt_res;
      else           legal = !tgt_res;
    end
  end

  assign accept_o = cmd_any && legal;
  assign reject_o = cmd_any && !legal;

  for (genvar g = 0; g < NUM_IRQS; g++) begin : g_bump
    assign bump[g] = (accept_o && use_i && (irq_i == IRQ_W'(g))) ||
                     (inc_i && (inc_idx_i == IRQ_W'(g)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQS; i++) begin
        counts_o[i]   <= '0;
        reserved_o[i] <= ~PERMIT_MASK[i];
      end
      err_o <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_IRQS; i++) begin
        if (accept_o && reserve_i && (irq_i == IRQ_W'(i))) reserved_o[i] <= 1'b1;
        if (bump[i]) counts_o[i] <= cnt_bump(counts_o[i]);
      end
      if (reject_o) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/alloc_link_table.sv
module alloc_link_table
  import irq_alloc_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int LINK_W = $clog2(NUM_LINKS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc_i,
  input  logic [LINK_W-1:0]       inc_idx_i,
  input  logic                    wr_i,
  input  logic [LINK_W-1:0]       wr_idx_i,
  input  route_t                  wr_data_i,
  output cnt_t [NUM_LINKS-1:0]    counts_o,
  output route_t [NUM_LINKS-1:0]  routes_o
);
  logic [NUM_LINKS-1:0] hit_inc, hit_wr;

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_hit
    assign hit_inc[g] = inc_i && (inc_idx_i == LINK_W'(g));
    assign hit_wr[g]  = wr_i  && (wr_idx_i  == LINK_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINKS; i++) begin
        counts_o[i] <= '0;
        routes_o[i] <= ROUTE_OFF;
      end
    end else begin
      for (int i = 0; i < NUM_LINKS; i++) begin
        if (hit_inc[i]) counts_o[i] <= cnt_bump(counts_o[i]);
        if (hit_wr[i])  routes_o[i] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/alloc_seq.sv
module alloc_seq
  import irq_alloc_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int NUM_IRQS  = 16,
  parameter int LINK_W    = $clog2(NUM_LINKS),
  parameter int IRQ_W     = $clog2(NUM_IRQS),
  parameter int PIN_W     = $clog2(NUM_LINKS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  cnt_t [NUM_LINKS-1:0]    link_counts_i,
  input  route_t [NUM_LINKS-1:0]  link_routes_i,
  input  cnt_t [NUM_IRQS-1:0]     irq_counts_i,
  input  logic [NUM_IRQS-1:0]     irq_reserved_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [PIN_W-1:0]        pin_o,
  output logic                    req_accept_o,
  output logic                    phase_open_o,
  output logic                    link_inc_o,
  output logic [LINK_W-1:0]       link_idx_o,
  output logic                    irq_inc_o,
  output logic [IRQ_W-1:0]        irq_idx_o,
  output logic                    route_wr_o,
  output logic [LINK_W-1:0]       route_link_o,
  output route_t                  route_data_o
);
  localparam int SCAN_W = (LINK_W > IRQ_W) ? LINK_W : IRQ_W;

  seq_state_t        state;
  logic [SCAN_W-1:0] scan, best_idx;
  cnt_t              best_cnt;
  logic              have;
  logic [LINK_W-1:0] link_sel;
  logic              cold;
  cnt_t              lcand, icand;
  logic              lbeat, ibeat, lend, iend;

  assign lcand = link_counts_i[scan[LINK_W-1:0]];
  assign icand = irq_counts_i[scan[IRQ_W-1:0]];
  assign lbeat = cnt_beats(have, lcand, best_cnt);
  assign ibeat = !irq_reserved_i[scan[IRQ_W-1:0]] && cnt_beats(have, icand, best_cnt);
  assign lend  = (scan == SCAN_W'(NUM_LINKS - 1));
  assign iend  = (scan == SCAN_W'(NUM_IRQS - 1));

  assign req_accept_o = (state == SQ_IDLE) && req_i;
  assign phase_open_o = cold && !req_accept_o;
  assign busy_o       = (state != SQ_IDLE);
  assign done_o       = (state == SQ_DONE);
  assign pin_o        = PIN_W'(link_sel) + PIN_W'(1);
  assign link_inc_o   = (state == SQ_LPICK);
  assign link_idx_o   = best_idx[LINK_W-1:0];
  assign irq_inc_o    = (state == SQ_IPICK) && have;
  assign irq_idx_o    = best_idx[IRQ_W-1:0];
  assign route_wr_o   = irq_inc_o;
  assign route_link_o = link_sel;
  assign route_data_o = route_t'(best_idx[IRQ_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      scan     <= '0;
      best_idx <= '0;
      best_cnt <= '0;
      have     <= 1'b0;
      link_sel <= '0;
      cold     <= 1'b1;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (req_i) begin
            state <= SQ_LSCAN;
            scan  <= '0;
            have  <= 1'b0;
            cold  <= 1'b0;
          end
        end
        SQ_LSCAN: begin
          if (lbeat) begin
            best_idx <= scan;
            best_cnt <= lcand;
            have     <= 1'b1;
          end
          if (lend) state <= SQ_LPICK;
          else      scan  <= scan + SCAN_W'(1);
        end
        SQ_LPICK: begin
          link_sel <= best_idx[LINK_W-1:0];
          if (link_routes_i[best_idx[LINK_W-1:0]] == ROUTE_OFF) begin
            state <= SQ_ISCAN;
            scan  <= '0;
            have  <= 1'b0;
          end else begin
            state <= SQ_DONE;
          end
        end
        SQ_ISCAN: begin
          if (ibeat) begin
            best_idx <= scan;
            best_cnt <= icand;
            have     <= 1'b1;
          end
          if (iend) state <= SQ_IPICK;
          else      scan  <= scan + SCAN_W'(1);
        end
        SQ_IPICK: state <= SQ_DONE;
        SQ_DONE:  state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_link_alloc.sv
module irq_link_alloc
  import irq_alloc_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int NUM_IRQS  = 16,
  parameter logic [NUM_IRQS-1:0] PERMIT_MASK = 16'hDEF8,
  parameter int LINK_W = $clog2(NUM_LINKS),
  parameter int IRQ_W  = $clog2(NUM_IRQS),
  parameter int PIN_W  = $clog2(NUM_LINKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req_i,
  input  logic              cfg_reserve_i,
  input  logic              cfg_use_i,
  input  logic [IRQ_W-1:0]  cfg_irq_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PIN_W-1:0]  pin_o,
  output logic              route_wr_o,
  output logic [LINK_W-1:0] route_link_o,
  output logic [7:0]        route_data_o,
  output logic              cfg_err_o
);
  // Named internal events, brought out for the checker
  cnt_t [NUM_LINKS-1:0]   link_counts_w;
  route_t [NUM_LINKS-1:0] link_routes_w;
  cnt_t [NUM_IRQS-1:0]    irq_counts_w;
  logic [NUM_IRQS-1:0]    irq_reserved_w;
  logic                   phase_open_w, req_accept_w;
  logic                   cmd_accept_w, cmd_reject_w;
  logic                   link_inc_w, irq_inc_w;
  logic [LINK_W-1:0]      link_idx_w;
  logic [IRQ_W-1:0]       irq_idx_w;
  route_t                 route_data_w;

  alloc_irq_table #(
    .NUM_IRQS(NUM_IRQS), .PERMIT_MASK(PERMIT_MASK), .IRQ_W(IRQ_W)
  ) u_irq (
    .clk(clk), .rst_n(rst_n),
    .phase_open_i(phase_open_w),
    .reserve_i(cfg_reserve_i), .use_i(cfg_use_i), .irq_i(cfg_irq_i),
    .inc_i(irq_inc_w), .inc_idx_i(irq_idx_w),
    .counts_o(irq_counts_w), .reserved_o(irq_reserved_w),
    .accept_o(cmd_accept_w), .reject_o(cmd_reject_w), .err_o(cfg_err_o)
  );

  alloc_link_table #(
    .NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W)
  ) u_link (
    .clk(clk), .rst_n(rst_n),
    .inc_i(link_inc_w), .inc_idx_i(link_idx_w),
    .wr_i(route_wr_o), .wr_idx_i(route_link_o), .wr_data_i(route_data_w),
    .counts_o(link_counts_w), .routes_o(link_routes_w)
  );

  alloc_seq #(
    .NUM_LINKS(NUM_LINKS), .NUM_IRQS(NUM_IRQS),
    .LINK_W(LINK_W), .IRQ_W(IRQ_W), .PIN_W(PIN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(alloc_req_i),
    .link_counts_i(link_counts_w), .link_routes_i(link_routes_w),
    .irq_counts_i(irq_counts_w), .irq_reserved_i(irq_reserved_w),
    .busy_o(busy_o), .done_o(done_o), .pin_o(pin_o),
    .req_accept_o(req_accept_w), .phase_open_o(phase_open_w),
    .link_inc_o(link_inc_w), .link_idx_o(link_idx_w),
    .irq_inc_o(irq_inc_w), .irq_idx_o(irq_idx_w),
    .route_wr_o(route_wr_o), .route_link_o(route_link_o),
    .route_data_o(route_data_w)
  );

  assign route_data_o = route_data_w;
endmodule

// File: rtl/irq_link_alloc_chk.sv
module irq_link_alloc_chk #(
  parameter int NUM_LINKS = 8,
  parameter int NUM_IRQS  = 16,
  parameter int IRQ_W     = $clog2(NUM_IRQS),
  parameter int PIN_W     = $clog2(NUM_LINKS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_req_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [PIN_W-1:0]    pin_o,
  input logic                route_wr_o,
  input logic [7:0]          route_data_o,
  input logic                cfg_err_o,
  input logic [NUM_IRQS-1:0] irq_reserved_w,
  input logic                cmd_accept_w
);
  assert_pin_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pin_o != '0) && (pin_o <= PIN_W'(NUM_LINKS)));

  assert_write_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    route_wr_o |-> busy_o && !done_o);

  assert_write_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    route_wr_o |-> !route_data_o[7]);

  assert_write_not_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    route_wr_o |-> !irq_reserved_w[route_data_o[IRQ_W-1:0]]);

  assert_cmd_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept_w |-> !busy_o);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(alloc_req_i));

  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));
endmodule

bind irq_link_alloc irq_link_alloc_chk #(
  .NUM_LINKS(NUM_LINKS), .NUM_IRQS(NUM_IRQS), .IRQ_W(IRQ_W), .PIN_W(PIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req_i(alloc_req_i),
  .busy_o(busy_o), .done_o(done_o), .pin_o(pin_o),
  .route_wr_o(route_wr_o), .route_data_o(route_data_o),
  .cfg_err_o(cfg_err_o), .irq_reserved_w(irq_reserved_w),
  .cmd_accept_w(cmd_accept_w)
);

// File: tb/tb_irq_link_alloc.sv
module tb_irq_link_alloc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_req_i = 1'b0;
  logic       cfg_reserve_i = 1'b0;
  logic       cfg_use_i = 1'b0;
  logic [3:0] cfg_irq_i = '0;
  logic       busy_o, done_o, route_wr_o, cfg_err_o;
  logic [3:0] pin_o;
  logic [2:0] route_link_o;
  logic [7:0] route_data_o;

  irq_link_alloc dut (
    .clk(clk), .rst_n(rst_n), .alloc_req_i(alloc_req_i),
    .cfg_reserve_i(cfg_reserve_i), .cfg_use_i(cfg_use_i), .cfg_irq_i(cfg_irq_i),
    .busy_o(busy_o), .done_o(done_o), .pin_o(pin_o),
    .route_wr_o(route_wr_o), .route_link_o(route_link_o),
    .route_data_o(route_data_o), .cfg_err_o(cfg_err_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Reference model state
  int m_lcnt [8];
  int m_icnt [16];
  bit m_res  [16];
  int m_route[8];
  bit m_cold, m_err;

  // Output monitors
  int wr_cnt = 0, wr_link = 0, wr_data = 0, done_cnt = 0;
  always @(negedge clk) begin
    if (route_wr_o) begin
      wr_cnt++; wr_link = route_link_o; wr_data = route_data_o;
    end
    if (done_o) done_cnt++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit allowed(int irq);
    return (irq >= 3 && irq <= 7) || (irq >= 9 && irq <= 12) || irq == 14 || irq == 15;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    alloc_req_i = 0; cfg_reserve_i = 0; cfg_use_i = 0;
    for (int i = 0; i < 8; i++) begin m_lcnt[i] = 0; m_route[i] = 'h80; end
    for (int i = 0; i < 16; i++) begin m_icnt[i] = 0; m_res[i] = !allowed(i); end
    m_cold = 1; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 = reserve, 1 = use, 2 = both at once
  task automatic cmd(int kind, int irq);
    bit ok;
    cfg_reserve_i = (kind != 1);
    cfg_use_i     = (kind != 0);
    cfg_irq_i     = irq[3:0];
    if (kind == 2) ok = 0;
    else if (kind == 0) ok = m_cold && (m_icnt[irq] == 0 || m_res[irq]);
    else ok = m_cold && !m_res[irq];
    if (!ok) m_err = 1;
    else if (kind == 0) m_res[irq] = 1;
    else if (m_icnt[irq] < 255) m_icnt[irq]++;
    @(negedge clk);
    cfg_reserve_i = 0; cfg_use_i = 0;
  endtask

  // One allocation: predict with the model, then compare
  task automatic alloc(string req);
    int bl, bc, bi, exp_wr, wait_n;
    bc = 1000; bl = 0;
    for (int i = 7; i >= 0; i--) if (m_lcnt[i] <= bc) begin bc = m_lcnt[i]; bl = i; end
    if (m_lcnt[bl] < 255) m_lcnt[bl]++;
    exp_wr = 0; bi = -1;
    if (m_route[bl] == 'h80) begin
      bc = 1000;
      for (int i = 15; i >= 0; i--)
        if (!m_res[i] && m_icnt[i] <= bc) begin bc = m_icnt[i]; bi = i; end
      if (bi >= 0) begin
        exp_wr = 1;
        if (m_icnt[bi] < 255) m_icnt[bi]++;
        m_route[bl] = bi;
      end
    end
    m_cold = 0;
    alloc_req_i = 1; wr_cnt = 0;
    @(negedge clk);
    alloc_req_i = 0;
    wait_n = 0;
    while (!done_o && wait_n < 100) begin @(negedge clk); wait_n++; end
    chk({req, " done seen"}, done_o, 1);
    chk({req, " pin"}, pin_o, bl + 1);
    chk({req, " write count"}, wr_cnt, exp_wr);
    if (exp_wr == 1) begin
      chk({req, " write link"}, wr_link, bl);
      chk({req, " write data"}, wr_data, bi);
    end
    @(negedge clk);
    chk({req, " busy cleared"}, busy_o, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R4 busy", busy_o, 0);
    chk("R4 done", done_o, 0);
    chk("R4 write", route_wr_o, 0);
    chk("R4 err", cfg_err_o, 0);
  endtask

  task automatic t_fill_links();
    do_reset();
    // R1 R3 R4: eight fresh links take permitted IRQs 3,4,5,6,7,9,10,11
    for (int k = 0; k < 8; k++) alloc("R1 R3 R4 fresh link");
    // R2: link 0 reused with its binding kept
    alloc("R2 reuse link");
    alloc("R2 reuse link b");
    chk("R2 no write on reuse", wr_cnt, 0);
  endtask

  task automatic t_config();
    do_reset();
    cmd(0, 3);          // R5 legal reserve
    cmd(1, 4); cmd(1, 4); // R6 use
    cmd(0, 0);          // R5 re-reserve of reserved IRQ
    chk("R5 R6 no err", cfg_err_o, 0);
    alloc("R5 R6 picks 5");
    chk("R5 write data", wr_data, 5);
  endtask

  task automatic t_illegal();
    do_reset();
    for (int i = 0; i < 16; i++) if (allowed(i)) cmd(1, i);
    cmd(0, 3);          // R5 illegal: count is 1
    chk("R8 err after bad reserve", cfg_err_o, 1);
    alloc("R8 reserve ignored, picks 3");
    chk("R8 write data", wr_data, 3);
    chk("R8 err sticky", cfg_err_o, 1);
    do_reset();
    cmd(1, 8);          // R6 illegal: IRQ 8 reserved
    chk("R6 err on reserved use", cfg_err_o, 1);
    do_reset();
    cmd(2, 3);          // R8 both commands at once
    chk("R8 err on double cmd", cfg_err_o, 1);
    alloc("R8 double cmd ignored");
    chk("R8 data after double", wr_data, 3);
  endtask

  task automatic t_late();
    do_reset();
    alloc("R7 first");
    cmd(1, 4); cmd(1, 4);
    chk("R7 err late", cfg_err_o, 1);
    alloc("R7 late use ignored");
    chk("R7 data", wr_data, 4);
  endtask

  task automatic t_busy();
    int d0;
    do_reset();
    d0 = done_cnt;
    alloc_req_i = 1;
    @(negedge clk);
    alloc_req_i = 0;
    chk("R10 busy after req", busy_o, 1);
    repeat (3) @(negedge clk);
    alloc_req_i = 1;     // ignored, block busy
    @(negedge clk);
    alloc_req_i = 0;
    repeat (40) @(negedge clk);
    chk("R10 single done", done_cnt - d0, 1);
    chk("R10 idle", busy_o, 0);
    m_cold = 0; m_lcnt[0] = 1; m_icnt[3] = 1; m_route[0] = 3;
    alloc("R10 next is pin 2");
  endtask

  task automatic t_all_reserved();
    do_reset();
    for (int i = 0; i < 16; i++) if (allowed(i)) cmd(0, i);
    chk("R11 no err", cfg_err_o, 0);
    alloc("R11 unrouted a");
    alloc("R11 unrouted b");
    chk("R11 pin 2 no write", wr_cnt, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < 300; k++) cmd(1, 3);
    for (int k = 0; k < 100; k++) cmd(1, 4);
    for (int i = 5; i < 16; i++) if (allowed(i)) cmd(0, i);
    chk("R9 no err", cfg_err_o, 0);
    alloc("R9 saturated 3 loses to 4");
    chk("R9 data", wr_data, 4);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill_links();
    t_config();
    t_illegal();
    t_late();
    t_busy();
    t_all_reserved();
    t_saturate();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule